// File: doc/BRIEF.md
# Shadowed Interrupt Status Controller

This block gathers twenty-four single-cycle event pulses into three 8-bit status bytes and drives one active-high interrupt request to a host processor. The host reaches the block through a plain byte-wide register port. The port has an address, write data, combinational read data, and read and write strobes.

Each status byte has two mask bytes. The capture mask decides whether an event is recorded at all. The line mask decides only whether a recorded bit can raise the request.

The host services the block in two steps. It first reads the status bytes, and that read arms a shadow register. It then writes any value to any one status byte, which acknowledges the interrupt. While the shadow is armed, newly arriving events are held in the shadow instead of main status. The acknowledge replaces all of main status with the shadow contents and empties the shadow. An event that lands between the host's read and its acknowledge is therefore never lost.

Top module: `shadow_irq_status`

## Requirements
- R1: After reset every status bit is 0, every mask byte reads 0xFF and `irq_o` is low.
- R2: Event input n is recorded in status byte n/8 at bit n%8. Status byte 0 (sources 0 to 7) is read at offset 0xD0, byte 1 at 0xD1 and byte 2 at 0xD2.
- R3: The capture mask bytes are at offsets 0xD6, 0xD7 and 0xD8, one per status byte. A set capture-mask bit stops the matching event from being recorded in either main status or the shadow.
- R4: The line mask bytes are at offsets 0xD3, 0xD4 and 0xD5. A set line-mask bit keeps its status bit from driving `irq_o`, but the bit is still recorded and can be read. Clearing the mask later raises the request.
- R5: `irq_o` is high in any cycle where a main status bit is 1 and its line-mask bit is 0. An event pulse is visible in status and on `irq_o` in the cycle after the edge that samples it.
- R6: A read strobe to any status offset arms the shadow. Events in that read cycle, and in every later cycle until the acknowledge, go only to the shadow, and main status stays unchanged.
- R7: A write of any data value to any of offsets 0xD0 to 0xD2 is an acknowledge. It loads main status from the shadow, clears the shadow and disarms it. Writes to mask offsets never acknowledge.
- R8: An event pulse arriving in the same cycle as an acknowledge appears in the new main status.
- R9: `irq_o` is low in the cycle after an acknowledge unless the loaded shadow or a same-cycle event holds an unmasked bit, in which case it stays high.
- R10: A read of an unmapped offset, or any cycle without a read strobe, returns 0x00. A write to an unmapped offset changes neither the masks nor the status.
- R11: Every mask byte reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 24 | Event pulses, one per source |
| addr_i | input | 8 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 8 | Read data, valid in the cycle of `rd_i` |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
If the arm flag is set wrongly, two symptoms follow. An event that should have waited in the shadow changes the status byte read back before the acknowledge, or it is missing from the byte read after it. Either shows at the very next status read. A shadow that is not cleared, or not copied, shows up on `irq_o` in the first cycle after the acknowledge. Mask decode slips show up as an unexpected status byte, or as `irq_o` moving one cycle after a single event pulse.

// File: rtl/shadow_irq_status.sv
module shadow_irq_status #(
  parameter int NUM_BYTES = 3,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 8,
  parameter logic [7:0] STS_BASE = 8'hD0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BYTES*BYTE_W-1:0]   evt_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [BYTE_W-1:0]             wdata_i,
  input  logic                          wr_i,
  input  logic                          rd_i,
  output logic [BYTE_W-1:0]             rdata_o,
  output logic                          irq_o
);

  localparam int NSRC = NUM_BYTES * BYTE_W;
  localparam logic [ADDR_W-1:0] NB_A      = ADDR_W'(NUM_BYTES);
  localparam logic [ADDR_W-1:0] STS_A     = ADDR_W'(STS_BASE);
  localparam logic [ADDR_W-1:0] LINE_A    = STS_A + NB_A;
  localparam logic [ADDR_W-1:0] CAP_A     = STS_A + NB_A + NB_A;

  logic [NSRC-1:0] sts, shd, line_msk, cap_msk;
  logic            armed;

  logic [ADDR_W-1:0] s_off, l_off, c_off;
  logic sts_hit, line_hit, cap_hit;
  logic ack, arm_now, to_shd;
  logic [NSRC-1:0] cap;

  assign s_off    = addr_i - STS_A;
  assign l_off    = addr_i - LINE_A;
  assign c_off    = addr_i - CAP_A;
  assign sts_hit  = (s_off < NB_A);
  assign line_hit = (l_off < NB_A);
  assign cap_hit  = (c_off < NB_A);

  assign ack     = wr_i & sts_hit;
  assign arm_now = rd_i & sts_hit & ~ack;
  assign to_shd  = armed | arm_now;
  assign cap     = evt_i & ~cap_msk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts   <= '0;
      shd   <= '0;
      armed <= 1'b0;
    end else if (ack) begin
      sts   <= shd | cap;
      shd   <= '0;
      armed <= 1'b0;
    end else begin
      if (to_shd) shd <= shd | cap;
      else        sts <= sts | cap;
      if (arm_now) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_msk <= '1;
      cap_msk  <= '1;
    end else if (wr_i) begin
      for (int k = 0; k < NUM_BYTES; k++) begin
        if (line_hit && l_off == ADDR_W'(k)) line_msk[k*BYTE_W +: BYTE_W] <= wdata_i;
        if (cap_hit  && c_off == ADDR_W'(k)) cap_msk[k*BYTE_W +: BYTE_W]  <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      for (int k = 0; k < NUM_BYTES; k++) begin
        if (sts_hit  && s_off == ADDR_W'(k)) rdata_o = sts[k*BYTE_W +: BYTE_W];
        if (line_hit && l_off == ADDR_W'(k)) rdata_o = line_msk[k*BYTE_W +: BYTE_W];
        if (cap_hit  && c_off == ADDR_W'(k)) rdata_o = cap_msk[k*BYTE_W +: BYTE_W];
      end
    end
  end

  assign irq_o = |(sts & ~line_msk);

  // R6
  armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ack) |=> $stable(sts));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (shd == '0 && !armed));

  // R7
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ((sts & $past(sts)) == $past(sts)));

  // R3
  cap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ((sts & ~$past(sts) & $past(cap_msk)) == '0));

  // R6
  shd_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shd != '0) |-> armed);

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && shd == '0 && (evt_i & ~cap_msk) == '0) |=> !irq_o);

endmodule

// File: tb/sim_shadow_irq_status.sv
module sim_shadow_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] evt_i = '0;
  logic [7:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        irq_o;

  shadow_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wr_i(wr_i), .rd_i(rd_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  typedef struct {
    bit        is_irq;
    logic [7:0] exp;
    string     tag;
  } item_t;

  item_t q[$];
  event  ev_s;
  int    errors = 0;
  int    checks = 0;

  initial begin
    forever begin
      @(ev_s);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (it.is_irq) begin
          if (irq_o !== it.exp[0]) begin
            errors++;
            $display("FAIL %s: irq_o actual=%0b expected=%0b", it.tag, irq_o, it.exp[0]);
          end
        end else if (rdata_o !== it.exp) begin
          errors++;
          $display("FAIL %s: rdata_o actual=%02h expected=%02h", it.tag, rdata_o, it.exp);
        end
      end
    end
  end

  task automatic op(input logic w, input logic [7:0] a, input logic [7:0] d, input logic [23:0] e);
    wr_i = w; addr_i = a; wdata_i = d; evt_i = e;
    @(negedge clk);
    wr_i = 1'b0; evt_i = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    op(1'b1, a, d, '0);
  endtask

  task automatic pulse(input logic [23:0] e);
    op(1'b0, 8'h00, 8'h00, e);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [23:0] e, input logic [7:0] exp, input string tag);
    item_t it;
    rd_i = 1'b1; addr_i = a; evt_i = e;
    #1;
    it.is_irq = 1'b0; it.exp = exp; it.tag = tag;
    q.push_back(it);
    ->ev_s;
    @(negedge clk);
    rd_i = 1'b0; evt_i = '0;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {7'd0, exp}; it.tag = tag;
    q.push_back(it);
    ->ev_s;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    irq_chk(1'b0, "R1 irq after reset");
    for (int a = 8'hD3; a <= 8'hD8; a++) rd_chk(8'(a), '0, 8'hFF, "R1 R11 mask reset value");
    for (int a = 8'hD0; a <= 8'hD2; a++) rd_chk(8'(a), '0, 8'h00, "R1 status reset value");
    wr(8'hD0, 8'hFF);

    for (int a = 8'hD3; a <= 8'hD8; a++) wr(8'(a), 8'h00);
    rd_chk(8'hD4, '0, 8'h00, "R11 line mask readback");
    rd_chk(8'hD7, '0, 8'h00, "R11 cap mask readback");

    pulse(24'h800201);
    irq_chk(1'b1, "R5 irq after event");
    rd_chk(8'hD0, '0, 8'h01, "R2 source 0");
    rd_chk(8'hD1, '0, 8'h02, "R2 source 9");
    rd_chk(8'hD2, '0, 8'h80, "R2 source 23");
    wr(8'hD1, 8'h5A);
    irq_chk(1'b0, "R9 irq low after ack");
    rd_chk(8'hD2, '0, 8'h00, "R7 status cleared");
    wr(8'hD0, 8'h00);

    pulse(24'h000008);
    rd_chk(8'hD0, '0, 8'h08, "R6 before shadow");
    pulse(24'h000020);
    rd_chk(8'hD0, '0, 8'h08, "R6 main unchanged while armed");
    irq_chk(1'b1, "R5 irq holds while armed");
    wr(8'hD2, 8'h33);
    irq_chk(1'b1, "R9 shadow reasserts irq");
    rd_chk(8'hD0, '0, 8'h20, "R7 shadow loaded into main");
    wr(8'hD0, 8'h00);
    irq_chk(1'b0, "R9 irq low after empty ack");

    rd_chk(8'hD1, 24'h001000, 8'h00, "R6 event in read cycle not in main");
    rd_chk(8'hD1, '0, 8'h00, "R6 read cycle event held in shadow");
    wr(8'hD1, 8'h00);
    rd_chk(8'hD1, '0, 8'h10, "R6 R7 read cycle event delivered");
    wr(8'hD0, 8'h00);

    op(1'b1, 8'hD0, 8'h00, 24'h010000);
    irq_chk(1'b1, "R8 irq from ack-cycle event");
    rd_chk(8'hD2, '0, 8'h01, "R8 ack-cycle event kept");
    wr(8'hD0, 8'h00);

    wr(8'hD6, 8'h01);
    pulse(24'h000003);
    rd_chk(8'hD0, '0, 8'h02, "R3 capture mask blocks main");
    wr(8'hD0, 8'h00);
    rd_chk(8'hD0, '0, 8'h00, "R3 arm");
    pulse(24'h000001);
    wr(8'hD0, 8'h00);
    rd_chk(8'hD0, '0, 8'h00, "R3 capture mask blocks shadow");
    wr(8'hD0, 8'h00);
    wr(8'hD6, 8'h00);

    wr(8'hD4, 8'hFF);
    pulse(24'h000100);
    irq_chk(1'b0, "R4 line mask gates irq");
    wr(8'hD4, 8'h00);
    irq_chk(1'b1, "R4 unmask raises irq");
    rd_chk(8'hD1, '0, 8'h01, "R4 masked bit still latched");
    wr(8'hD0, 8'h00);

    pulse(24'h000004);
    wr(8'hD3, 8'h00);
    irq_chk(1'b1, "R7 mask write is not ack");
    rd_chk(8'hD0, '0, 8'h04, "R7 status kept across mask write");
    wr(8'hD0, 8'h00);

    wr(8'hD9, 8'hAA);
    wr(8'hCF, 8'hAA);
    rd_chk(8'hD9, '0, 8'h00, "R10 unmapped read D9");
    rd_chk(8'h10, '0, 8'h00, "R10 unmapped read 10");
    rd_chk(8'hD8, '0, 8'h00, "R10 mask untouched by unmapped write");
    rd_chk(8'hD3, '0, 8'h00, "R10 line mask untouched");
    irq_chk(1'b0, "R10 no irq from unmapped write");
    wr_i = 1'b0; rd_i = 1'b0; addr_i = 8'hD3;
    irq_chk(1'b0, "R10 idle");
    begin
      item_t it;
      it.is_irq = 1'b0; it.exp = 8'h00; it.tag = "R10 no strobe returns zero";
      q.push_back(it);
      ->ev_s;
      @(negedge clk);
    end

    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule